// File: doc/BRIEF.md
# Bit-Serial Constant-Coefficient FIR Filter

This block filters a stream of signed samples with a short FIR whose coefficients are fixed when the design is elaborated. It has no multipliers. All partial sums of the coefficients are computed at elaboration and stored in a table with one entry per subset of taps. When the block accepts a sample, it shifts the sample into a tap line. It then walks the sample bits from least to most significant, one bit weight per clock. In each cycle the bits of that weight from every tap together form the table address. The table entry is added into an accumulator that is halved every cycle. The bits that shift out are kept, so the final sum has no rounding.

A producer pulses `sampleValid` with a sample on `sampleData`. After `SAMPLE_W` clocks the block pulses `resultValid` for one cycle and presents the exact filter output on `resultData`. It holds that value until the next result. The block can accept a new sample in the same cycle that it finishes the last bit of the previous one, so it sustains one sample every `SAMPLE_W` clocks.

Top module: `da_fir`

## Requirements
- R1: After reset, `resultValid` and `resultData` are 0 and every tap holds 0. The first result after reset therefore treats all older samples as zero.
- R2: Each result equals the exact sum of `coef[n] * sample[k-n]` for n = 0..NTAPS-1. Here `sample[k]` is the newest accepted sample, and `coef[n]` is the signed `COEF_W`-bit field at bits `[n*COEF_W +: COEF_W]` of `COEFS`.
- R3: `resultValid` rises exactly `SAMPLE_W` clock edges after the edge that accepts a sample, and it stays high for one cycle only.
- R4: Samples and coefficients are two's complement. Results are correct for the most negative sample value (-2048 with 12-bit samples), because the most significant bit weight is subtracted rather than added.
- R5: `sampleValid` asserted while a result is still being built, other than in its final bit cycle, is ignored. It leaves the tap history and all later results unchanged.
- R6: A sample offered in the final bit cycle of the previous computation is accepted, so back-to-back samples complete one every `SAMPLE_W` cycles.
- R7: `resultData` is 25-bit two's complement with the default parameters, and it holds its value while `resultValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe offering `sampleData` as the next sample |
| sampleData | input | SAMPLE_W | Two's-complement input sample |
| resultValid | output | 1 | One-cycle pulse marking a new filter output |
| resultData | output | COEF_W+clog2(NTAPS)+1+SAMPLE_W | Exact two's-complement filter output |

## Verification
The bench uses full-scale positive samples, the most negative sample, and alternating extremes. A design that added the top bit weight instead of subtracting it would give wrong signs or magnitudes on these patterns. A design that rounded off the low bits shifted out of the accumulator would differ by a few LSBs. An impulse followed by zeros must return each coefficient in tap order, which exposes a reversed tap line or a misindexed table. A strobe placed in the middle of a computation must not perturb the history. Back-to-back samples offered exactly on the final bit cycle must all be taken, so a controller that drops them or accepts them one cycle early produces missing results or wrong timing.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Strobes passed from the sequencer to the datapath each cycle.
  typedef struct packed {
    logic load;       // capture sampleData into the tap line, restart accumulation
    logic step;       // process the current bit plane
    logic lastPlane;  // current plane is the sign plane: subtract and finish
  } fir_ctrl_t;

endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int IDX_W = $clog2(SAMPLE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  output fir_ctrl_t        ctrlBus,
  output logic [IDX_W-1:0] planeIdx
);

  logic             busy;
  logic [IDX_W-1:0] planeCnt;
  logic             atLast;
  logic             loadNow;

  assign atLast  = busy && (planeCnt == IDX_W'(SAMPLE_W - 1));
  assign loadNow = sampleValid && (!busy || atLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      planeCnt <= '0;
    end else if (loadNow) begin
      busy     <= 1'b1;
      planeCnt <= '0;
    end else if (atLast) begin
      busy     <= 1'b0;
    end else if (busy) begin
      planeCnt <= planeCnt + 1'b1;
    end
  end

  assign ctrlBus.load      = loadNow;
  assign ctrlBus.step      = busy;
  assign ctrlBus.lastPlane = atLast;
  assign planeIdx          = planeCnt;

endmodule

// File: rtl/da_fir_table.sv
module da_fir_table #(
  parameter int                        NTAPS  = 4,
  parameter int                        COEF_W = 10,
  parameter logic [NTAPS*COEF_W-1:0]   COEFS  = '0,
  parameter int                        TW     = COEF_W + $clog2(NTAPS),
  localparam int                       ENTRIES = 1 << NTAPS
) (
  input  logic        [NTAPS-1:0] addr,
  output logic signed [TW-1:0]    entry
);

  // Sum of the coefficients whose tap bit is set in the address.
  function automatic logic signed [TW-1:0] subsetSum(input int unsigned sel);
    logic signed [TW-1:0]     acc;
    logic        [COEF_W-1:0] c;
    acc = '0;
    for (int n = 0; n < NTAPS; n++) begin
      c = COEFS[n*COEF_W +: COEF_W];
      if (((sel >> n) & 1) != 0)
        acc = acc + {{(TW-COEF_W){c[COEF_W-1]}}, c};
    end
    return acc;
  endfunction

  logic signed [TW-1:0] romTable [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign romTable[g] = subsetSum(g);
  end

  assign entry = romTable[addr];

endmodule

// File: rtl/da_fir_datapath.sv
module da_fir_datapath
  import da_fir_pkg::*;
#(
  parameter int                      NTAPS    = 4,
  parameter int                      SAMPLE_W = 12,
  parameter int                      COEF_W   = 10,
  parameter logic [NTAPS*COEF_W-1:0] COEFS    = '0,
  localparam int IDX_W = $clog2(SAMPLE_W),
  localparam int TW    = COEF_W + $clog2(NTAPS),
  localparam int RES_W = TW + 1 + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  fir_ctrl_t           ctrlBus,
  input  logic [IDX_W-1:0]    planeIdx,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                resultValid,
  output logic [RES_W-1:0]    resultData
);

  logic [SAMPLE_W-1:0]  taps [NTAPS];
  logic [NTAPS-1:0]     planeAddr;
  logic signed [TW-1:0] tableOut;
  logic signed [TW:0]   hiAcc;        // running sum of the upper bits
  logic [SAMPLE_W-2:0]  lowBits;      // bits already shifted out of hiAcc
  logic signed [TW+1:0] tableExt;
  logic signed [TW+1:0] addend;
  logic signed [TW+1:0] partial;

  // One bit of the current weight from every tap forms the table address.
  for (genvar n = 0; n < NTAPS; n++) begin : gPlane
    assign planeAddr[n] = taps[n][planeIdx];
  end

  da_fir_table #(
    .NTAPS (NTAPS),
    .COEF_W(COEF_W),
    .COEFS (COEFS),
    .TW    (TW)
  ) u_table (
    .addr (planeAddr),
    .entry(tableOut)
  );

  assign tableExt = {{2{tableOut[TW-1]}}, tableOut};
  assign addend   = ctrlBus.lastPlane ? -tableExt : tableExt;
  assign partial  = {hiAcc[TW], hiAcc} + addend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < NTAPS; n++) taps[n] <= '0;
      hiAcc       <= '0;
      lowBits     <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (ctrlBus.step) begin
        if (ctrlBus.lastPlane) begin
          resultData  <= {partial, lowBits};
          resultValid <= 1'b1;
        end else begin
          hiAcc   <= partial[TW+1:1];
          lowBits <= {partial[0], lowBits[SAMPLE_W-2:1]};
        end
      end
      if (ctrlBus.load) begin
        taps[0] <= sampleData;
        for (int n = 1; n < NTAPS; n++) taps[n] <= taps[n-1];
        hiAcc <= '0;
      end
    end
  end

endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int                      NTAPS    = 4,
  parameter int                      SAMPLE_W = 12,
  parameter int                      COEF_W   = 10,
  parameter logic [NTAPS*COEF_W-1:0] COEFS    = {10'h200, 10'h1FF, 10'h377, 10'h03A},
  localparam int IDX_W = $clog2(SAMPLE_W),
  localparam int RES_W = COEF_W + $clog2(NTAPS) + 1 + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                resultValid,
  output logic [RES_W-1:0]    resultData
);

  fir_ctrl_t        ctrlBus;
  logic [IDX_W-1:0] planeIdx;

  da_fir_ctrl #(
    .SAMPLE_W(SAMPLE_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ctrlBus    (ctrlBus),
    .planeIdx   (planeIdx)
  );

  da_fir_datapath #(
    .NTAPS   (NTAPS),
    .SAMPLE_W(SAMPLE_W),
    .COEF_W  (COEF_W),
    .COEFS   (COEFS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlBus    (ctrlBus),
    .planeIdx   (planeIdx),
    .sampleData (sampleData),
    .resultValid(resultValid),
    .resultData (resultData)
  );

endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int SAMPLE_W = 12,
  parameter int RES_W    = 25,
  localparam int PH_W    = $clog2(SAMPLE_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             load,
  input logic             resultValid,
  input logic [RES_W-1:0] resultData
);

  // Independent phase count: 1 after the accepting edge, SAMPLE_W in the final bit cycle.
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN)                             phase <= '0;
    else if (load)                         phase <= PH_W'(1);
    else if (phase == PH_W'(SAMPLE_W))     phase <= '0;
    else if (phase != '0)                  phase <= phase + 1'b1;
  end

  assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_W'(SAMPLE_W)) |=> resultValid);

  assert_result_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ($past(phase) == PH_W'(SAMPLE_W)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_busy_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase != '0 && phase != PH_W'(SAMPLE_W)) |-> !load);

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (phase == '0 || phase == PH_W'(SAMPLE_W))) |-> load);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultData));

endmodule

bind da_fir da_fir_checker #(
  .SAMPLE_W(SAMPLE_W),
  .RES_W   (RES_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .load       (ctrlBus.load),
  .resultValid(resultValid),
  .resultData (resultData)
);

// File: tb/tb_da_fir.sv
module tb_da_fir;

  localparam int CLK_PERIOD = 10;
  localparam int NTAPS      = 4;
  localparam int SAMPLE_W   = 12;
  localparam int COEF_W     = 10;
  localparam int RES_W      = COEF_W + $clog2(NTAPS) + 1 + SAMPLE_W;
  localparam logic [NTAPS*COEF_W-1:0] COEF_PACK = {10'h200, 10'h1FF, 10'h377, 10'h03A};
  localparam int COEF [NTAPS] = '{58, -137, 511, -512};

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sampleData = '0;
  logic                resultValid;
  logic [RES_W-1:0]    resultData;

  da_fir #(
    .NTAPS(NTAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .COEFS(COEF_PACK)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .resultValid(resultValid), .resultData(resultData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     cycle = 0;
  int     checks = 0;
  int     fails = 0;
  int     hist [NTAPS];
  longint expVal [$];
  int     expCyc [$];
  longint lastExp = 0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: offers one sample, predicts its result, then leaves SAMPLE_W-1+idle negedges.
  // With idle = 0 the next sample lands on the final bit cycle (back to back, R6).
  task automatic send(input int x, input int idle, input bit poke);
    longint acc;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = x[SAMPLE_W-1:0];
    @(posedge clk);
    #1;
    for (int n = NTAPS-1; n > 0; n--) hist[n] = hist[n-1];
    hist[0] = x;
    acc = 0;
    for (int n = 0; n < NTAPS; n++) acc += longint'(COEF[n]) * longint'(hist[n]);
    expVal.push_back(acc);
    expCyc.push_back(cycle + SAMPLE_W);
    lastExp = acc;
    @(negedge clk);
    sampleValid = 1'b0;
    for (int k = 2; k <= SAMPLE_W - 1 + idle; k++) begin
      @(negedge clk);
      // R5: a strobe mid-computation with a junk value must be ignored
      if (poke && k == 4) begin
        sampleValid = 1'b1;
        sampleData  = 12'h5A5;
      end else begin
        sampleValid = 1'b0;
      end
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expVal.size() == 0) begin
        check(1'b0, "R5 unexpected result", longint'($signed(resultData)), 0);
      end else begin
        longint ev;
        int     ec;
        ev = expVal.pop_front();
        ec = expCyc.pop_front();
        check(longint'($signed(resultData)) == ev, "R2/R4 value", longint'($signed(resultData)), ev);
        check(cycle == ec, "R3 latency", cycle, ec);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cycle, 0);
    finishRun();
  end

  initial begin
    for (int n = 0; n < NTAPS; n++) hist[n] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(resultValid == 1'b0, "R1 resultValid after reset", resultValid, 0);
    check(resultData == '0, "R1 resultData after reset", resultData, 0);

    // R1/R2/R6: impulse then zeros back to back returns coefficients in tap order
    send(1, 0, 0);
    send(0, 0, 0);
    send(0, 0, 0);
    send(0, 0, 0);
    send(0, 3, 0);
    // R4: full-scale positive, most negative, alternating extremes
    for (int i = 0; i < 4; i++) send(2047, 0, 0);
    for (int i = 0; i < 4; i++) send(-2048, 0, 0);
    for (int i = 0; i < 6; i++) send((i % 2) ? -2048 : 2047, 0, 0);
    send(-1, 2, 0);
    // R5: strobes while busy have no effect on history or results
    send(100, 0, 1);
    send(-5, 1, 1);
    send(733, 0, 1);
    send(-1500, 0, 0);
    // mixed pattern with varied gaps
    for (int i = 0; i < 40; i++) begin
      int v;
      v = int'($urandom_range(0, 4095)) - 2048;
      send(v, int'($urandom_range(0, 3)), (i % 7) == 3);
    end
    repeat (SAMPLE_W + 6) @(negedge clk);
    // R7: output holds the last result while idle
    check(resultValid == 1'b0, "R7 idle valid", resultValid, 0);
    check(longint'($signed(resultData)) == lastExp, "R7 hold", longint'($signed(resultData)), lastExp);
    check(expVal.size() == 0, "R3 missing results", expVal.size(), 0);
    finishRun();
  end

endmodule